// File: doc/BRIEF.md
# Accumulator ALU with Compare Flag

This block is the arithmetic and logic stage of a small accumulator machine. Every operation takes the accumulator as its first operand. The second operand is either a register value or an immediate byte, chosen by a select input. The block returns a result that the surrounding datapath writes back into the accumulator. A carry-lookahead adder/subtractor, a bitwise logic unit, a one-position circular rotator and an operand bypass all feed one result multiplexer.

Compare operations leave the accumulator unchanged: the result equals the accumulator input. Instead, they write a single condition flag. That flag is the block's only state. It holds the truth of one of five unsigned relations between the accumulator and the operand. The relation is taken from the subtractor's difference and borrow. Every other operation leaves the flag as it was. Carry and overflow are not produced.

Top module: `alu_flag_core`

## Requirements
- R1: Operation code 0 (add) gives result = (acc + operand) modulo 2^WIDTH.
- R2: Operation code 1 (subtract) gives result = (acc - operand) modulo 2^WIDTH.
- R3: Operation codes 2, 3 and 4 give the bitwise and, or and xor of acc with the operand.
- R4: Operation code 5 gives the bitwise complement of acc, whatever the operand is.
- R5: Operation code 6 rotates acc left by one bit, with the top bit moving into bit 0. Code 7 rotates acc right by one bit, with bit 0 moving into the top bit.
- R6: Operation code 8 passes the operand to the result. The operand is `imm_val` when `use_imm` is 1 and `reg_val` when it is 0, and this selection applies to every operation.
- R7: Operation code 9 (compare) loads the flag at the next rising clock edge with the unsigned relation picked by `cmp_sel`: 0 means equal, 1 means acc < operand, 2 means acc <= operand, 3 means acc > operand, 4 means acc >= operand.
- R8: During operation code 9 the result equals acc.
- R9: Any operation code other than 9 leaves the flag unchanged at the clock edge.
- R10: While `rst_n` is low at a rising edge the flag is cleared to 0. This holds even if a true compare is presented at the same edge.
- R11: Operation codes 10 to 15 give result = acc and leave the flag unchanged. A compare with `cmp_sel` 5, 6 or 7 loads the flag with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset of the flag |
| op_sel | input | 4 | Operation code |
| cmp_sel | input | 3 | Relation code used by compare |
| acc_in | input | WIDTH | Accumulator value |
| reg_val | input | WIDTH | Register operand |
| imm_val | input | WIDTH | Immediate operand |
| use_imm | input | 1 | 1 selects the immediate operand, 0 selects the register |
| result | output | WIDTH | Value to write back into the accumulator |
| flag | output | 1 | Condition flag register |

## Verification
The bench builds the block with its defaults: WIDTH of 8 and a lookahead group size of 4. The adder therefore has two lookahead groups, and a carry must cross from the low group into the high group. Vectors such as 0x0F + 0x01 and 0xFF + 0x01 exercise that crossing, as do subtractions that borrow through both groups. Equal operands and zero-versus-0xFF pairs probe each of the five relations at its boundary. Long stretches of non-compare operations with a set flag show that the flag holds its value.

// File: rtl/alu_flag_pkg.sv
// Shared encodings for the accumulator ALU.
package alu_flag_pkg;

    // Operation codes presented on op_sel.
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOT  = 4'd5,
        OP_ROL  = 4'd6,
        OP_ROR  = 4'd7,
        OP_PASS = 4'd8,
        OP_CMP  = 4'd9
    } alu_op_e;

    // Relation codes presented on cmp_sel.
    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_LT = 3'd1,
        REL_LE = 3'd2,
        REL_GT = 3'd3,
        REL_GE = 3'd4
    } cmp_rel_e;

    // Internal function select of the logic unit.
    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOT = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/alu_cla_adder.sv
// Carry-lookahead adder. Inside each group of GROUP bits the carries come
// from the group carry-in. Group generate/propagate terms then form the
// carries between groups. Assumes WIDTH is a multiple of GROUP.
module alu_cla_adder #(
    parameter int WIDTH = 8,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NGRP = WIDTH / GROUP;

    logic [NGRP-1:0] grp_g;
    logic [NGRP-1:0] grp_p;
    logic [NGRP:0]   grp_c;

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        logic [GROUP-1:0] bit_g;
        logic [GROUP-1:0] bit_p;
        logic [GROUP-1:0] bit_c;

        // Per-bit generate and propagate terms.
        always_comb begin
            bit_g = a[gi*GROUP +: GROUP] & b[gi*GROUP +: GROUP];
            bit_p = a[gi*GROUP +: GROUP] ^ b[gi*GROUP +: GROUP];
        end

        // Carries inside the group, derived from the group carry-in.
        always_comb begin
            bit_c[0] = grp_c[gi];
            for (int j = 1; j < GROUP; j++) begin
                bit_c[j] = bit_g[j-1] | (bit_p[j-1] & bit_c[j-1]);
            end
        end

        // Group generate and propagate summary.
        always_comb begin
            logic gacc;
            logic pacc;
            gacc = 1'b0;
            pacc = 1'b1;
            for (int j = 0; j < GROUP; j++) begin
                gacc = bit_g[j] | (bit_p[j] & gacc);
                pacc = pacc & bit_p[j];
            end
            grp_g[gi] = gacc;
            grp_p[gi] = pacc;
        end

        assign sum[gi*GROUP +: GROUP] = bit_p ^ bit_c;
    end

    // Carries between groups, taken from the group summaries.
    always_comb begin
        grp_c[0] = cin;
        for (int k = 0; k < NGRP; k++) begin
            grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);
        end
    end

    assign cout = grp_c[NGRP];

endmodule

// File: rtl/alu_logic_unit.sv
// Bitwise logic unit: and, or or xor of the two inputs, or the complement
// of the first input. The second input is unused for the complement.
module alu_logic_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);
    // Select the bitwise function.
    always_comb begin
        unique case (fn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            default: y = ~a;
        endcase
    end

endmodule

// File: rtl/alu_rotator.sv
// Circular rotate by one bit position. dir_right = 0 moves each bit up one
// place and wraps the top bit to bit 0. dir_right = 1 does the reverse.
module alu_rotator #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             dir_right,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int SRC_L = (i == 0) ? WIDTH - 1 : i - 1;
        localparam int SRC_R = (i == WIDTH - 1) ? 0 : i + 1;
        assign y[i] = dir_right ? a[SRC_R] : a[SRC_L];
    end

endmodule

// File: rtl/alu_compare.sv
// Unsigned relation evaluator. It works from the difference acc - operand
// and the adder carry-out, which is 1 when no borrow occurred. Assumes the
// adder is in subtract mode whenever its output is used.
module alu_compare
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] diff,
    input  logic             no_borrow,
    input  logic [2:0]       rel,
    output logic             hit
);
    logic is_eq;
    logic is_lt;

    // Equality from a zero difference; less-than from a borrow.
    always_comb begin
        is_eq = (diff == '0);
        is_lt = ~no_borrow;
    end

    // Pick the requested relation; unused codes give false.
    always_comb begin
        case (rel)
            REL_EQ:  hit = is_eq;
            REL_LT:  hit = is_lt;
            REL_LE:  hit = is_lt | is_eq;
            REL_GT:  hit = ~(is_lt | is_eq);
            REL_GE:  hit = ~is_lt;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flag_core.sv
// Accumulator ALU with a compare flag. The result path is combinational.
// The flag is a register written only by compare operations and cleared
// by a synchronous active-low reset. The caller is assumed to hold the
// inputs stable around the rising clock edge.
module alu_flag_core
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int GROUP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_sel,
    input  logic [2:0]       cmp_sel,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] reg_val,
    input  logic [WIDTH-1:0] imm_val,
    input  logic             use_imm,
    output logic [WIDTH-1:0] result,
    output logic             flag
);
    logic [WIDTH-1:0] opnd;
    logic             sub_mode;
    logic [WIDTH-1:0] add_b;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic_fn_e        lfn;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] rot_y;
    logic             cmp_hit;
    logic             is_cmp;

    // Operand select and adder mode from the operation code.
    always_comb begin
        opnd     = use_imm ? imm_val : reg_val;
        is_cmp   = (op_sel == OP_CMP);
        sub_mode = (op_sel == OP_SUB) || is_cmp;
        add_b    = sub_mode ? ~opnd : opnd;
    end

    // Map the operation code to the logic unit's function select.
    always_comb begin
        case (op_sel)
            OP_AND:  lfn = LF_AND;
            OP_OR:   lfn = LF_OR;
            OP_XOR:  lfn = LF_XOR;
            default: lfn = LF_NOT;
        endcase
    end

    alu_cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_add (
        .a    (acc_in),
        .b    (add_b),
        .cin  (sub_mode),
        .sum  (add_sum),
        .cout (add_cout)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a  (acc_in),
        .b  (opnd),
        .fn (lfn),
        .y  (logic_y)
    );

    alu_rotator #(.WIDTH(WIDTH)) u_rot (
        .a         (acc_in),
        .dir_right (op_sel == OP_ROR),
        .y         (rot_y)
    );

    alu_compare #(.WIDTH(WIDTH)) u_cmp (
        .diff      (add_sum),
        .no_borrow (add_cout),
        .rel       (cmp_sel),
        .hit       (cmp_hit)
    );

    // Result multiplexer over the four paths plus accumulator hold.
    always_comb begin
        case (op_sel)
            OP_ADD, OP_SUB:        result = add_sum;
            OP_AND, OP_OR,
            OP_XOR, OP_NOT:        result = logic_y;
            OP_ROL, OP_ROR:        result = rot_y;
            OP_PASS:               result = opnd;
            default:               result = acc_in;
        endcase
    end

    // Flag register: cleared by reset, loaded only on compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (is_cmp) begin
            flag <= cmp_hit;
        end
    end

endmodule

// File: rtl/alu_flag_chk.sv
// Property checker for alu_flag_core, attached by bind. It observes ports only.
module alu_flag_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_sel,
    input logic [2:0]       cmp_sel,
    input logic [WIDTH-1:0] acc_in,
    input logic [WIDTH-1:0] reg_val,
    input logic [WIDTH-1:0] imm_val,
    input logic             use_imm,
    input logic [WIDTH-1:0] result,
    input logic             flag
);
    logic [WIDTH-1:0] ck_opnd;
    assign ck_opnd = use_imm ? imm_val : reg_val;

    p_add_wraps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd0) |-> (result == WIDTH'(acc_in + ck_opnd)));

    p_sub_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd1) |-> (result == WIDTH'(acc_in - ck_opnd)));

    p_not_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd5) |-> (result == ~acc_in));

    p_rol_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd6) |-> (result[0] == acc_in[WIDTH-1]));

    p_ror_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd7) |-> (result[WIDTH-1] == acc_in[0]));

    p_pass_opnd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd8) |-> (result == ck_opnd));

    p_cmp_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd9 && cmp_sel == 3'd0) |=>
        (flag == ($past(acc_in) == $past(ck_opnd))));

    p_cmp_lt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd9 && cmp_sel == 3'd1) |=>
        (flag == ($past(acc_in) < $past(ck_opnd))));

    p_cmp_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd9) |-> (result == acc_in));

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 4'd9) |=> $stable(flag));

    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> !flag);

    p_bad_rel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd9 && cmp_sel > 3'd4) |=> !flag);

endmodule

bind alu_flag_core alu_flag_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .cmp_sel (cmp_sel),
    .acc_in  (acc_in),
    .reg_val (reg_val),
    .imm_val (imm_val),
    .use_imm (use_imm),
    .result  (result),
    .flag    (flag)
);

// File: tb/alu_flag_core_tb.sv
`timescale 1ns/1ps
module alu_flag_core_tb;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_sel = '0;
    logic [2:0]   cmp_sel = '0;
    logic [W-1:0] acc_in = '0;
    logic [W-1:0] reg_val = '0;
    logic [W-1:0] imm_val = '0;
    logic         use_imm = 1'b0;
    logic [W-1:0] result;
    logic         flag;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_flag = 0;

    always #2 clk = ~clk;

    alu_flag_core #(.WIDTH(W), .GROUP(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .cmp_sel(cmp_sel),
        .acc_in(acc_in), .reg_val(reg_val), .imm_val(imm_val),
        .use_imm(use_imm), .result(result), .flag(flag)
    );

    // Requirement tag for the result of a given operation.
    function automatic string res_tag(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R3";
            5: return "R4";
            6, 7: return "R5";
            8: return "R6";
            9: return "R8";
            default: return "R11";
        endcase
    endfunction

    // Expected result from the requirements.
    function automatic int model_res(int op, int a, int b);
        case (op)
            0: return (a + b) & MASK;
            1: return (a - b) & MASK;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return (~a) & MASK;
            6: return ((a << 1) | (a >> (W - 1))) & MASK;
            7: return ((a >> 1) | (a << (W - 1))) & MASK;
            8: return b;
            default: return a;
        endcase
    endfunction

    // Expected relation from the requirements (unsigned).
    function automatic int model_rel(int rel, int a, int b);
        case (rel)
            0: return int'(a == b);
            1: return int'(a < b);
            2: return int'(a <= b);
            3: return int'(a > b);
            4: return int'(a >= b);
            default: return 0;
        endcase
    endfunction

    // Drive one cycle, check the result mid-cycle and the flag after the edge.
    task automatic step(input int op, input int rel, input int a, input int r,
                        input int im, input int ui, input int rst);
        int b;
        int er;
        string ftag;
        @(negedge clk);
        op_sel  = 4'(op);
        cmp_sel = 3'(rel);
        acc_in  = W'(a);
        reg_val = W'(r);
        imm_val = W'(im);
        use_imm = ui[0];
        rst_n   = rst[0];
        b  = ui ? (im & MASK) : (r & MASK);
        er = model_res(op, a & MASK, b);
        #1;
        n_checks++;
        if (int'(result) != er) begin
            n_fail++;
            $display("FAIL %s op=%0d result actual=%0h expected=%0h",
                     res_tag(op), op, result, er);
        end
        if (!rst) begin
            exp_flag = 0;
            ftag = "R10";
        end else if (op == 9) begin
            exp_flag = model_rel(rel, a & MASK, b);
            ftag = (rel > 4) ? "R11" : "R7";
        end else begin
            ftag = "R9";
        end
        @(posedge clk);
        #1;
        n_checks++;
        if (int'(flag) != exp_flag) begin
            n_fail++;
            $display("FAIL %s op=%0d rel=%0d flag actual=%0d expected=%0d",
                     ftag, op, rel, flag, exp_flag);
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Reset state; R10 also with a true compare during reset.
        step(9, 0, 5, 5, 0, 0, 0);
        step(9, 4, 9, 1, 0, 0, 0);
        // R1 add, with carries across the group boundary and wrap-around.
        step(0, 0, 8'h0F, 8'h01, 0, 0, 1);
        step(0, 0, 8'hFF, 0, 8'h01, 1, 1);
        step(0, 0, 8'h7F, 8'h80, 8'h33, 0, 1);
        // R2 subtract, with a borrow through both groups.
        step(1, 0, 8'h00, 8'h01, 0, 0, 1);
        step(1, 0, 8'h10, 0, 8'h01, 1, 1);
        // R3 and R4 logic; R4 with different operands gives the same result.
        step(2, 0, 8'hF0, 8'h3C, 0, 0, 1);
        step(3, 0, 8'hF0, 0, 8'h0F, 1, 1);
        step(4, 0, 8'hAA, 8'hFF, 0, 0, 1);
        step(5, 0, 8'h5A, 8'h00, 0, 0, 1);
        step(5, 0, 8'h5A, 8'hFF, 8'h12, 1, 1);
        // R5 rotates at both ends.
        step(6, 0, 8'h80, 0, 0, 0, 1);
        step(7, 0, 8'h01, 0, 0, 0, 1);
        step(6, 0, 8'hC3, 0, 0, 0, 1);
        // R6 pass of register and immediate.
        step(8, 0, 8'h11, 8'h22, 8'h33, 0, 1);
        step(8, 0, 8'h11, 8'h22, 8'h33, 1, 1);
        // R7 relations at equality and at the extremes; R8 result is acc.
        for (int rel = 0; rel < 5; rel++) begin
            step(9, rel, 8'h40, 8'h40, 0, 0, 1);
            step(9, rel, 8'h00, 0, 8'hFF, 1, 1);
            step(9, rel, 8'hFF, 8'h00, 0, 0, 1);
        end
        // R9 flag held across every other code after a true compare.
        step(9, 0, 3, 3, 0, 0, 1);
        for (int op = 0; op < 16; op++) begin
            if (op != 9) step(op, 1, 8'h77, 8'h01, 8'h02, op & 1, 1);
        end
        // R11 unused relation codes clear the flag.
        step(9, 5, 1, 1, 0, 0, 1);
        step(9, 4, 1, 1, 0, 0, 1);
        step(9, 7, 2, 1, 0, 0, 1);
        // Mixed sweep against the reference model.
        for (int i = 0; i < 600; i++) begin
            step(int'($urandom_range(15)), int'($urandom_range(7)),
                 int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), int'($urandom_range(1)),
                 (i % 97 == 50) ? 0 : 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule